// File: doc/BRIEF.md
# SD Host Interrupt and Programmed-I/O Register Block

This block is the interrupt and programmed-I/O corner of an SD host controller. It holds the raw interrupt status word, the interrupt mask, the global control word, the card status word and a handful of plain configuration words. It drives one level interrupt line. Other units of the host raise status bits through a one-cycle set vector. A card-detect level produces the insert and remove events.

Software moves data without DMA through a 32-bit data-port address. A word written there leaves toward the card as four bytes on a byte stream, least significant byte first. Bytes arriving from the card are gathered into a staging word, and a read of the data port returns that word once four bytes are present. Each word moved through the port counts down a transfer counter by four. The counter stops at zero, and every access that leaves it at zero raises the data-complete status bit. Writing the byte-count address reloads that counter.

Top module: `sdh_irq_pio`

## Requirements
- R1: After reset the words read as follows: control (0x00) 0x0000_0300, card status (0x10) 0x0000_0100, block size (0x14) 0x0000_0200, byte count (0x18) 0x0000_0200, timeout (0x1C) 0xFFFF_FF40, water level (0x20) 0x000F_0000. The mask (0x04), raw status (0x08) and masked status (0x0C) read zero.
- R2: A read of 0x0C returns raw status AND mask. `irq` is high exactly when control bit 4 is set and raw AND mask is nonzero.
- R3: Writing to 0x08 or to 0x0C clears every raw status bit that is one in the written data. All other raw bits are kept.
- R4: Each one bit of `set_evt` sets the same raw bit at the next edge. When a set (from `set_evt`, a card event or data-complete) and a clearing write hit the same bit in one cycle, the bit ends up set.
- R5: When `card_det` differs from the present bit (card status bit 8), the next edge records an event. Insertion sets raw bit 30, clears raw bit 31 and sets bit 8. Removal clears raw bit 30, sets raw bit 31 and clears bit 8.
- R6: A write to control stores bits 31..3. Bits 2..0 always read back zero.
- R7: A write to the byte-count address (0x18) stores the value for read-back and loads the transfer counter with it.
- R8: A write to the data port (0x40) puts its four bytes on `tx_byte` with `tx_valid` high for four consecutive cycles, starting the cycle after the write and in the order bits 7..0, 15..8, 23..16, 31..24.
- R9: Card bytes on `rx_byte` with `rx_valid` fill a staging word in arrival order from bits 7..0 upward, and `rx_full` rises when four are held. A data-port read while `rx_full` returns that word and empties the staging. A data-port read without `rx_full` returns zero and leaves the transfer counter unchanged.
- R10: A data-port write, and a data-port read while `rx_full`, each reduce the transfer counter by 4, stopping at zero. Every such access that leaves the counter at zero sets raw bit 3 (data complete).
- R11: Read data appears on `reg_rdata` the cycle after `reg_rd` and holds until the next read. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| set_evt | input | 32 | One-cycle set vector from the command and DMA units |
| card_det | input | 1 | Card-detect level, high when a card is inserted |
| rx_valid | input | 1 | Card byte valid |
| rx_byte | input | 8 | Card byte toward the host |
| rx_full | output | 1 | Four card bytes staged; data-port read will return them |
| tx_valid | output | 1 | Byte toward the card valid |
| tx_byte | output | 8 | Byte toward the card |
| irq | output | 1 | Interrupt line |

## Verification
The assertions take for granted that the card side never offers a byte while `rx_full` is high, and that no data-port write arrives while a previous word is still leaving on `tx_byte`. The checker states both as properties. The stimulus keeps within them. It pushes card bytes only into a non-full staging word, and after each data-port write it waits out the four byte cycles before the next. The stimulus also never writes the byte-count address and touches the data port in the same cycle, since the assertions leave that combination's ordering unstated.

// File: rtl/sdh_pkg.sv
package sdh_pkg;

  localparam int DW = 32;
  localparam int AW = 8;
  localparam int BYTES = DW / 8;

  // Register byte addresses
  localparam logic [AW-1:0] OFS_CTRL = 8'h00;
  localparam logic [AW-1:0] OFS_MASK = 8'h04;
  localparam logic [AW-1:0] OFS_RAW  = 8'h08;
  localparam logic [AW-1:0] OFS_MSKD = 8'h0C;
  localparam logic [AW-1:0] OFS_CARD = 8'h10;
  localparam logic [AW-1:0] OFS_BLK  = 8'h14;
  localparam logic [AW-1:0] OFS_BCNT = 8'h18;
  localparam logic [AW-1:0] OFS_TMO  = 8'h1C;
  localparam logic [AW-1:0] OFS_WLVL = 8'h20;
  localparam logic [AW-1:0] OFS_FIFO = 8'h40;

  // Bit positions other logic depends on
  localparam int BIT_IRQ_EN  = 4;
  localparam int BIT_DONE    = 3;
  localparam int BIT_INS     = 30;
  localparam int BIT_REM     = 31;
  localparam int BIT_PRESENT = 8;
  localparam logic [DW-1:0] SELF_CLR = 32'h0000_0007;

  localparam logic [DW-1:0] RST_CTRL = 32'h0000_0300;

  // Plain storage words, built by a generate loop
  localparam int NPLAIN   = 5;
  localparam int PIX_MASK = 0;
  localparam int PIX_BLK  = 1;
  localparam int PIX_BCNT = 2;
  localparam int PIX_TMO  = 3;
  localparam int PIX_WLVL = 4;
  localparam logic [AW-1:0] PLAIN_OFS [NPLAIN] =
    '{OFS_MASK, OFS_BLK, OFS_BCNT, OFS_TMO, OFS_WLVL};
  localparam logic [DW-1:0] PLAIN_RST [NPLAIN] =
    '{32'h0, 32'h0000_0200, 32'h0000_0200, 32'hFFFF_FF40, 32'h000F_0000};

  // Control word as stored: the reset-request bits never stick
  function automatic logic [DW-1:0] ctrl_store(input logic [DW-1:0] v);
    return v & ~SELF_CLR;
  endfunction

  // Card status word from the present flag
  function automatic logic [DW-1:0] card_word(input logic present);
    logic [DW-1:0] w;
    w = '0;
    w[BIT_PRESENT] = present;
    return w;
  endfunction

  // One byte lane of a word, lane 0 being bits 7..0
  function automatic logic [7:0] lane_of(input logic [DW-1:0] w, input int k);
    return w[8*k +: 8];
  endfunction

endpackage

// File: rtl/sdh_irq_core.sv
module sdh_irq_core #(
  parameter int W       = 32,
  parameter int INS_BIT = 30,
  parameter int REM_BIT = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] clr_vec,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] mask,
  input  logic         irq_en,
  input  logic         card_det,
  output logic [W-1:0] raw_q,
  output logic         present_q,
  output logic         evt_ins,
  output logic         evt_rem,
  output logic         irq
);

  logic [W-1:0] raw_r;
  logic [W-1:0] raw_d;
  logic         pres_r;

  assign evt_ins = card_det & ~pres_r;
  assign evt_rem = ~card_det & pres_r;

  // Clears first, then sets, then card events own their two bits
  always_comb begin
    raw_d = (raw_r & ~clr_vec) | set_vec;
    if (evt_ins) begin
      raw_d[INS_BIT] = 1'b1;
      raw_d[REM_BIT] = 1'b0;
    end else if (evt_rem) begin
      raw_d[INS_BIT] = 1'b0;
      raw_d[REM_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_r  <= '0;
      pres_r <= 1'b1;
    end else begin
      raw_r  <= raw_d;
      pres_r <= card_det;
    end
  end

  assign raw_q     = raw_r;
  assign present_q = pres_r;
  assign irq       = irq_en & (|(raw_r & mask));

endmodule

// File: rtl/sdh_xfer_ctr.sv
module sdh_xfer_ctr #(
  parameter int CNT_W = 32,
  parameter int STEP  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic             done
);

  localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

  logic [CNT_W-1:0] cnt_r;
  logic [CNT_W-1:0] cnt_dec;

  function automatic logic [CNT_W-1:0] sat_down(input logic [CNT_W-1:0] v);
    if (v > STEP_V) return v - STEP_V;
    return '0;
  endfunction

  assign cnt_dec = sat_down(cnt_r);
  assign done    = step & (cnt_dec == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_r <= '0;
    else if (load) cnt_r <= load_val;
    else if (step) cnt_r <= cnt_dec;
  end

endmodule

// File: rtl/sdh_pio_port.sv
module sdh_pio_port #(
  parameter int BYTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_word,
  input  logic [8*BYTES-1:0] wdata,
  input  logic               rd_req,
  input  logic               rx_valid,
  input  logic [7:0]         rx_byte,
  output logic               tx_valid,
  output logic [7:0]         tx_byte,
  output logic               rx_full,
  output logic               rd_ok,
  output logic [8*BYTES-1:0] rx_word
);

  localparam int W  = 8 * BYTES;
  localparam int CW = $clog2(BYTES + 1);
  localparam logic [CW-1:0] NBYTES = CW'(BYTES);

  logic [W-1:0]  tx_sh;
  logic [CW-1:0] tx_left;
  logic [CW-1:0] rx_cnt;
  logic          rx_take;

  // Toward the card: shift out lane 0 first
  assign tx_valid = (tx_left != '0);
  assign tx_byte  = tx_sh[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      tx_left <= '0;
    end else if (wr_word) begin
      tx_sh   <= wdata;
      tx_left <= NBYTES;
    end else if (tx_valid) begin
      tx_sh   <= tx_sh >> 8;
      tx_left <= tx_left - 1'b1;
    end
  end

  // From the card: gather bytes into lanes in arrival order
  assign rx_full = (rx_cnt == NBYTES);
  assign rd_ok   = rd_req & rx_full;
  assign rx_take = rx_valid & ~rx_full & ~rd_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_cnt <= '0;
    else if (rd_ok) rx_cnt <= '0;
    else if (rx_take) rx_cnt <= rx_cnt + 1'b1;
  end

  for (genvar k = 0; k < BYTES; k++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= '0;
      else if (rx_take && rx_cnt == CW'(k)) lane_q <= rx_byte;
    end
    assign rx_word[8*k +: 8] = lane_q;
  end

endmodule

// File: rtl/sdh_cfg_regs.sv
module sdh_cfg_regs
  import sdh_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] plain_q [NPLAIN]
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= RST_CTRL;
    else if (wr_en && addr == OFS_CTRL) ctrl_q <= ctrl_store(wdata);
  end

  for (genvar i = 0; i < NPLAIN; i++) begin : g_plain
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= PLAIN_RST[i];
      else if (wr_en && addr == PLAIN_OFS[i]) q <= wdata;
    end
    assign plain_q[i] = q;
  end

endmodule

// File: rtl/sdh_irq_pio.sv
module sdh_irq_pio
  import sdh_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [DW-1:0] set_evt,
  input  logic          card_det,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  output logic          rx_full,
  output logic          tx_valid,
  output logic [7:0]    tx_byte,
  output logic          irq
);

  // Named internal events, also watched by the checker
  logic          fifo_wr;
  logic          fifo_rd_req;
  logic          rd_ok;
  logic          xfer_done;
  logic          evt_ins;
  logic          evt_rem;
  logic          present_q;
  logic [DW-1:0] raw_q;
  logic [DW-1:0] ctrl_q;
  logic [DW-1:0] plain_q [NPLAIN];
  logic [DW-1:0] clr_vec;
  logic [DW-1:0] set_vec;
  logic [DW-1:0] rx_word;
  logic [DW-1:0] rd_mux;
  logic          bcnt_load;

  assign fifo_wr     = reg_wr & (reg_addr == OFS_FIFO);
  assign fifo_rd_req = reg_rd & (reg_addr == OFS_FIFO);
  assign bcnt_load   = reg_wr & (reg_addr == OFS_BCNT);
  assign clr_vec     = (reg_wr && (reg_addr == OFS_RAW || reg_addr == OFS_MSKD))
                       ? reg_wdata : '0;
  assign set_vec     = set_evt | (DW'(xfer_done) << BIT_DONE);

  sdh_cfg_regs u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .ctrl_q  (ctrl_q),
    .plain_q (plain_q)
  );

  sdh_irq_core #(
    .W       (DW),
    .INS_BIT (BIT_INS),
    .REM_BIT (BIT_REM)
  ) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_vec   (clr_vec),
    .set_vec   (set_vec),
    .mask      (plain_q[PIX_MASK]),
    .irq_en    (ctrl_q[BIT_IRQ_EN]),
    .card_det  (card_det),
    .raw_q     (raw_q),
    .present_q (present_q),
    .evt_ins   (evt_ins),
    .evt_rem   (evt_rem),
    .irq       (irq)
  );

  sdh_xfer_ctr #(
    .CNT_W (CNT_W),
    .STEP  (BYTES)
  ) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (bcnt_load),
    .load_val (reg_wdata[CNT_W-1:0]),
    .step     (fifo_wr | rd_ok),
    .done     (xfer_done)
  );

  sdh_pio_port #(
    .BYTES (BYTES)
  ) u_pio (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_word  (fifo_wr),
    .wdata    (reg_wdata),
    .rd_req   (fifo_rd_req),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .tx_valid (tx_valid),
    .tx_byte  (tx_byte),
    .rx_full  (rx_full),
    .rd_ok    (rd_ok),
    .rx_word  (rx_word)
  );

  always_comb begin
    case (reg_addr)
      OFS_CTRL: rd_mux = ctrl_q;
      OFS_MASK: rd_mux = plain_q[PIX_MASK];
      OFS_RAW:  rd_mux = raw_q;
      OFS_MSKD: rd_mux = raw_q & plain_q[PIX_MASK];
      OFS_CARD: rd_mux = card_word(present_q);
      OFS_BLK:  rd_mux = plain_q[PIX_BLK];
      OFS_BCNT: rd_mux = plain_q[PIX_BCNT];
      OFS_TMO:  rd_mux = plain_q[PIX_TMO];
      OFS_WLVL: rd_mux = plain_q[PIX_WLVL];
      OFS_FIFO: rd_mux = rd_ok ? rx_word : '0;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

endmodule

// File: rtl/sdh_irq_pio_chk.sv
module sdh_irq_pio_chk
  import sdh_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] set_evt,
  input logic          rx_valid,
  input logic          rx_full,
  input logic          tx_valid,
  input logic          irq,
  input logic [DW-1:0] raw_q,
  input logic [DW-1:0] ctrl_q,
  input logic          present_q,
  input logic          evt_ins,
  input logic          evt_rem,
  input logic          xfer_done,
  input logic          fifo_wr,
  input logic          rd_ok
);

  localparam logic [DW-1:0] NON_CARD = 32'h3FFF_FFFF;

  // R2: a disabled interrupt enable keeps the line low
  p_irq_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[BIT_IRQ_EN] |-> !irq);

  // R3: a clearing write with no competing set empties the written bits
  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == OFS_RAW || reg_addr == OFS_MSKD) &&
     set_evt == '0 && !evt_ins && !evt_rem && !xfer_done)
    |=> ((raw_q & $past(reg_wdata)) == '0));

  // R4: every pulsed bit outside the card pair is set next cycle
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_evt & NON_CARD) != '0)
    |=> ((raw_q & $past(set_evt & NON_CARD)) == $past(set_evt & NON_CARD)));

  // R5: insertion and removal events
  p_insert_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ins |=> (raw_q[BIT_INS] && !raw_q[BIT_REM] && present_q));

  p_remove_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rem |=> (!raw_q[BIT_INS] && raw_q[BIT_REM] && !present_q));

  // R6: control keeps the upper bits of a write, never the low three
  p_ctrl_selfclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_CTRL)
    |=> (ctrl_q == {$past(reg_wdata[DW-1:3]), 3'b000}));

  // R8: a data-port write finds the byte stream idle and starts it
  p_tx_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> !tx_valid);

  p_tx_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |=> tx_valid);

  // R9: card never pushes into a full staging word; a read empties it
  p_rx_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !rx_full);

  p_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok |=> !rx_full);

  // R10: reaching zero raises data complete
  p_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> raw_q[BIT_DONE]);

endmodule

bind sdh_irq_pio sdh_irq_pio_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .set_evt   (set_evt),
  .rx_valid  (rx_valid),
  .rx_full   (rx_full),
  .tx_valid  (tx_valid),
  .irq       (irq),
  .raw_q     (raw_q),
  .ctrl_q    (ctrl_q),
  .present_q (present_q),
  .evt_ins   (evt_ins),
  .evt_rem   (evt_rem),
  .xfer_done (xfer_done),
  .fifo_wr   (fifo_wr),
  .rd_ok     (rd_ok)
);

// File: tb/sdh_irq_pio_bench.sv
module sdh_irq_pio_bench;

  localparam int CLK_PERIOD = 10;

  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_MASK = 8'h04;
  localparam logic [7:0] A_RAW  = 8'h08;
  localparam logic [7:0] A_MSKD = 8'h0C;
  localparam logic [7:0] A_CARD = 8'h10;
  localparam logic [7:0] A_BLK  = 8'h14;
  localparam logic [7:0] A_BCNT = 8'h18;
  localparam logic [7:0] A_TMO  = 8'h1C;
  localparam logic [7:0] A_WLVL = 8'h20;
  localparam logic [7:0] A_FIFO = 8'h40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] set_evt = '0;
  logic        card_det = 1'b1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_full;
  logic        tx_valid;
  logic [7:0]  tx_byte;
  logic        irq;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sdh_irq_pio u_sdh_irq_pio (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .set_evt   (set_evt),
    .card_det  (card_det),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .rx_full   (rx_full),
    .tx_valid  (tx_valid),
    .tx_byte   (tx_byte),
    .irq       (irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done_run = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit [31:0] m_raw, m_mask, m_ctrl, m_blk, m_bcnt, m_tmo, m_wlvl, m_rdata;
  bit        m_present;
  longint    m_cnt;
  bit [7:0]  txq[$];
  bit [7:0]  rxq[$];
  bit        rd_pend;
  bit [31:0] v_set, v_clr, v_raw;
  bit        v_acc, v_ok;

  function automatic bit [31:0] model_read(input bit [7:0] a, input bit ok);
    case (a)
      A_CTRL: return m_ctrl;
      A_MASK: return m_mask;
      A_RAW:  return m_raw;
      A_MSKD: return m_raw & m_mask;
      A_CARD: return m_present ? 32'h100 : 32'h0;
      A_BLK:  return m_blk;
      A_BCNT: return m_bcnt;
      A_TMO:  return m_tmo;
      A_WLVL: return m_wlvl;
      A_FIFO: return ok ? {rxq[3], rxq[2], rxq[1], rxq[0]} : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_raw = 0; m_mask = 0; m_ctrl = 32'h300; m_blk = 32'h200;
      m_bcnt = 32'h200; m_tmo = 32'hFFFF_FF40; m_wlvl = 32'h000F_0000;
      m_rdata = 0; m_present = 1'b1; m_cnt = 0; rd_pend = 1'b0;
      txq.delete(); rxq.delete();
    end else begin
      v_ok = (rxq.size() == 4);
      if (reg_rd) m_rdata = model_read(reg_addr, v_ok);
      rd_pend = reg_rd;
      v_acc = (reg_wr && reg_addr == A_FIFO) || (reg_rd && reg_addr == A_FIFO && v_ok);
      v_set = set_evt;
      v_clr = (reg_wr && (reg_addr == A_RAW || reg_addr == A_MSKD)) ? reg_wdata : 32'h0;
      if (v_acc) begin
        m_cnt = (m_cnt > 4) ? m_cnt - 4 : 0;
        if (m_cnt == 0) v_set[3] = 1'b1;
      end
      if (reg_wr && reg_addr == A_BCNT) m_cnt = longint'(reg_wdata);
      v_raw = (m_raw & ~v_clr) | v_set;
      if (card_det && !m_present) begin v_raw[30] = 1'b1; v_raw[31] = 1'b0; end
      if (!card_det && m_present) begin v_raw[30] = 1'b0; v_raw[31] = 1'b1; end
      m_raw = v_raw;
      m_present = card_det;
      if (reg_wr) begin
        case (reg_addr)
          A_CTRL: m_ctrl = reg_wdata & 32'hFFFF_FFF8;
          A_MASK: m_mask = reg_wdata;
          A_BLK:  m_blk = reg_wdata;
          A_BCNT: m_bcnt = reg_wdata;
          A_TMO:  m_tmo = reg_wdata;
          A_WLVL: m_wlvl = reg_wdata;
          default: ;
        endcase
      end
      if (txq.size() != 0) void'(txq.pop_front());
      if (reg_wr && reg_addr == A_FIFO)
        for (int k = 0; k < 4; k++) txq.push_back(reg_wdata[8*k +: 8]);
      if (reg_rd && reg_addr == A_FIFO && v_ok) rxq.delete();
      else if (rx_valid && rxq.size() < 4) rxq.push_back(rx_byte);
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done_run) begin
      check("R2 irq", 32'(irq), 32'(m_ctrl[4] && ((m_raw & m_mask) != 0)));
      check("R8 tx_valid", 32'(tx_valid), 32'(txq.size() != 0));
      if (txq.size() != 0) check("R8 tx_byte", 32'(tx_byte), 32'(txq[0]));
      check("R9 rx_full", 32'(rx_full), 32'(rxq.size() == 4));
      if (rd_pend) check("R11 rdata", reg_rdata, m_rdata);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    check(tag, reg_rdata, exp);
  endtask

  task automatic pulse_set(input logic [31:0] v);
    @(negedge clk);
    set_evt = v;
    @(negedge clk);
    set_evt = '0;
  endtask

  task automatic push_rx(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic fifo_send(input logic [31:0] w);
    bus_wr(A_FIFO, w);
    for (int k = 0; k < 4; k++) begin
      check("R8 byte order", 32'(tx_byte), 32'(w[8*k +: 8]));
      @(negedge clk);
    end
    check("R8 burst ends", 32'(tx_valid), 32'h0);
  endtask

  // Watchdog
  initial begin
    #(CLK_PERIOD * 20000);
    if (!done_run) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=timeout exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset words
    check("R1 irq low", 32'(irq), 32'h0);
    bus_rd(A_CTRL, 32'h0000_0300, "R1 ctrl");
    bus_rd(A_CARD, 32'h0000_0100, "R1 card status");
    bus_rd(A_BLK,  32'h0000_0200, "R1 block size");
    bus_rd(A_BCNT, 32'h0000_0200, "R1 byte count");
    bus_rd(A_TMO,  32'hFFFF_FF40, "R1 timeout");
    bus_rd(A_WLVL, 32'h000F_0000, "R1 water level");
    bus_rd(A_RAW,  32'h0, "R1 raw");
    bus_rd(A_MASK, 32'h0, "R1 mask");
    bus_rd(A_MSKD, 32'h0, "R1 masked");
    bus_rd(8'h7C,  32'h0, "R11 unmapped");

    // R4 set pulses, R2 masking
    pulse_set(32'h0000_0006);
    bus_rd(A_RAW, 32'h0000_0006, "R4 set pulse");
    bus_wr(A_MASK, 32'h0000_0004);
    bus_rd(A_MSKD, 32'h0000_0004, "R2 masked read");
    check("R2 irq off while disabled", 32'(irq), 32'h0);

    // R6 self-clearing control bits, R2 enable
    bus_wr(A_CTRL, 32'h0000_0317);
    check("R2 irq on when enabled", 32'(irq), 32'h1);
    bus_rd(A_CTRL, 32'h0000_0310, "R6 ctrl low bits");

    // R3 clear through both addresses
    bus_wr(A_MSKD, 32'h0000_0004);
    check("R3 irq drops after clear", 32'(irq), 32'h0);
    bus_rd(A_RAW, 32'h0000_0002, "R3 clear via masked");
    bus_wr(A_RAW, 32'h0000_0002);
    bus_rd(A_RAW, 32'h0, "R3 clear via raw");

    // R4 set beats clear in the same cycle
    @(negedge clk);
    set_evt = 32'h0000_0100; reg_wr = 1'b1; reg_addr = A_RAW; reg_wdata = 32'h0000_0101;
    @(negedge clk);
    set_evt = '0; reg_wr = 1'b0;
    bus_rd(A_RAW, 32'h0000_0100, "R4 set wins");
    bus_wr(A_RAW, 32'hFFFF_FFFF);

    // R5 card removal and insertion
    @(negedge clk); card_det = 1'b0;
    bus_rd(A_RAW, 32'h8000_0000, "R5 removal raw");
    bus_rd(A_CARD, 32'h0, "R5 removal present");
    @(negedge clk); card_det = 1'b1;
    bus_rd(A_RAW, 32'h4000_0000, "R5 insertion raw");
    bus_rd(A_CARD, 32'h0000_0100, "R5 insertion present");

    // R5 with R4: card event against a clearing write
    @(negedge clk);
    card_det = 1'b0; reg_wr = 1'b1; reg_addr = A_RAW; reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    reg_wr = 1'b0;
    bus_rd(A_RAW, 32'h8000_0000, "R5 event beats clear");
    @(negedge clk); card_det = 1'b1;
    bus_wr(A_RAW, 32'hFFFF_FFFF);
    bus_rd(A_RAW, 32'h0, "R3 all cleared");

    // R7, R8, R10 data-port writes
    bus_wr(A_MASK, 32'h0000_0008);
    bus_wr(A_BCNT, 32'h0000_0008);
    bus_rd(A_BCNT, 32'h0000_0008, "R7 byte count");
    fifo_send(32'hA1B2_C3D4);
    bus_rd(A_RAW, 32'h0, "R10 no complete at 4 left");
    fifo_send(32'h1122_3344);
    bus_rd(A_RAW, 32'h0000_0008, "R10 complete at zero");
    check("R2 irq on data complete", 32'(irq), 32'h1);
    bus_wr(A_RAW, 32'h0000_0008);

    // R9 reads with and without staged data
    bus_wr(A_BCNT, 32'h0000_0006);
    bus_rd(A_FIFO, 32'h0, "R9 empty read");
    for (int k = 1; k <= 4; k++) push_rx(8'(k));
    check("R9 staged full", 32'(rx_full), 32'h1);
    bus_rd(A_FIFO, 32'h0403_0201, "R9 word order");
    check("R9 emptied", 32'(rx_full), 32'h0);
    bus_rd(A_RAW, 32'h0, "R9 empty read left counter");
    for (int k = 5; k <= 8; k++) push_rx(8'(k));
    bus_rd(A_FIFO, 32'h0807_0605, "R9 second word");
    bus_rd(A_RAW, 32'h0000_0008, "R10 saturated to zero");
    bus_wr(A_RAW, 32'h0000_0008);
    bus_rd(A_FIFO, 32'h0, "R9 empty read at zero");
    bus_rd(A_RAW, 32'h0, "R9 empty read no complete");
    fifo_send(32'hDEAD_BEEF);
    bus_rd(A_RAW, 32'h0000_0008, "R10 repeat complete at zero");

    // R2 disable with pending masked status
    bus_wr(A_CTRL, 32'h0);
    check("R2 irq gated off", 32'(irq), 32'h0);
    bus_rd(A_MSKD, 32'h0000_0008, "R2 masked still set");

    repeat (3) @(negedge clk);
    done_run = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule